// File: doc/BRIEF.md
# Shared-Pool Twin Stack Unit

This block keeps two last-in-first-out stacks inside one array of 16-bit cells. The data stack starts at the low end of the pool and grows toward higher addresses. The exit stack starts at the high end and grows toward lower addresses. Neither stack has a fixed share of the pool, so either one may use every free cell until the two stacks meet. Each stack is tracked by a pointer that always holds the address of its next empty cell, never the address of the occupied top.

A client issues one command at a time on a command port: an operation code, a stack select, a depth and write data. A command is taken on a clock edge where `cmd_valid` is high and `busy` is low. The simple operations are push, pop, read-top, read-second and overwrite-top. Each of them completes with a one-cycle `done` pulse in the cycle after it is taken. The indexed operations tuck and roll shift one element per clock inside the array. They hold `busy` high for depth+2 cycles and then pulse `done`. Read results appear on `rd_data`, and an error code appears on `err`, both in the `done` cycle. Both pointers are visible on ports at all times.

Top module: `twin_stack_pool`

## Requirements
- R1: After reset, `data_ptr` equals the pool's low cell (6), `exit_ptr` equals the pool's high cell (511), and both `busy` and `done` are 0.
- R2: Push (op 0) writes `cmd_wdata` into the selected stack's next empty cell. The pointer then moves one cell away from that stack's base: the data pointer by +1 (stack select 0) and the exit pointer by -1 (stack select 1). `done` is 1 and `err` is 0 in the cycle after the command is taken.
- R3: A push is refused with `err` = 1 (overflow) only when the pool is completely used, that is when `data_ptr` equals `exit_ptr`+1. Nothing changes in that case. Either stack alone may fill every cell the other stack leaves free.
- R4: Pop (op 1) returns the most recently pushed and not yet removed value on `rd_data` in the `done` cycle, and moves the pointer back by one cell.
- R5: Pop, read-top (op 2) and overwrite-top (op 4) on an empty stack, and read-second (op 3) on a stack holding fewer than two elements, end with `err` = 2 (underflow). Both pointers stay unchanged.
- R6: Read-top returns element 0 and read-second returns element 1, counted from the top. Neither changes the stack or its pointer.
- R7: Overwrite-top replaces element 0 with `cmd_wdata` and leaves the pointer unchanged.
- R8: Tuck (op 5) with depth k inserts a copy of element 0 just below element k, so the stack grows by one. Depth 0 acts as duplicate. `busy` is 1 for exactly k+2 cycles, and `done` follows in the next cycle.
- R9: Roll (op 6) with depth k removes element k, closes the gap, and places the removed value on top. The pointer does not change. `busy` is 1 for exactly k+2 cycles, and `done` follows in the next cycle.
- R10: Tuck or roll with a depth not smaller than the element count, and the reserved op 7, end with `err` = 3 (rejected) and leave the stack unmodified. A tuck with a valid depth on a full pool ends with `err` = 1.
- R11: `cmd_valid` is ignored while `busy` is 1.
- R12: A command on one stack never changes the other stack's pointer or contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present; taken when `busy` is 0 |
| cmd_op | input | 3 | 0 push, 1 pop, 2 read-top, 3 read-second, 4 overwrite-top, 5 tuck, 6 roll, 7 reserved |
| cmd_sel | input | 1 | 0 data stack, 1 exit stack |
| cmd_depth | input | DEPTH_W | Element index for tuck and roll |
| cmd_wdata | input | DATA_W | Value for push and overwrite-top |
| busy | output | 1 | Tuck or roll in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read result, valid in the `done` cycle of a successful read |
| err | output | 2 | 0 ok, 1 overflow, 2 underflow, 3 rejected; valid with `done` |
| data_ptr | output | ADDR_W+1 | Next empty data-stack cell |
| exit_ptr | output | ADDR_W+1 | Next empty exit-stack cell |

## Verification
Tuck and roll are tried at depths 0, 1, 2, 3 and 4, on both stacks. Depths 0 and 1 separate a step counter that is off by one from a correct one. The deeper cases separate correct per-step addressing from a single swap of two cells. Subsequent reads check the full stack contents, because a wrong shift order shows up as a duplicated or lost element that a pointer check alone would miss. The pool is filled with an uneven split, 300 data cells and the rest exit cells, which separates a collision test from a halfway limit. Underflow and rejected depths are tried on empty, one-element and full stacks, and each is followed by pointer checks at the ports.

// File: rtl/twin_stack_pkg.sv
package twin_stack_pkg;
   typedef enum logic [2:0] {
      OP_PUSH   = 3'd0,
      OP_POP    = 3'd1,
      OP_TOP    = 3'd2,
      OP_SECOND = 3'd3,
      OP_SETTOP = 3'd4,
      OP_TUCK   = 3'd5,
      OP_ROLL   = 3'd6,
      OP_RSVD   = 3'd7
   } stk_op_e;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0,
      ERR_OVF  = 2'd1,
      ERR_UNF  = 2'd2,
      ERR_REJ  = 2'd3
   } stk_err_e;
endpackage

// File: rtl/tsp_cell_array.sv
module tsp_cell_array #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int CELLS = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [CELLS];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
      rdata <= cells[raddr];
   end
endmodule

// File: rtl/tsp_ptr_pair.sv
module tsp_ptr_pair #(
   parameter int PTR_W   = 10,
   parameter int LO_CELL = 6,
   parameter int HI_CELL = 511
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             grow,
   input  logic             shrink,
   output logic [PTR_W-1:0] ptr_d,
   output logic [PTR_W-1:0] ptr_e
);
   for (genvar g = 0; g < 2; g++) begin : g_side
      localparam logic [PTR_W-1:0] HOME = (g == 0) ? PTR_W'(LO_CELL) : PTR_W'(HI_CELL);
      localparam logic [PTR_W-1:0] UP   = (g == 0) ? PTR_W'(1) : {PTR_W{1'b1}};
      logic [PTR_W-1:0] p;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p <= HOME;
         else if (sel == 1'(g)) begin
            if (grow)        p <= p + UP;
            else if (shrink) p <= p - UP;
         end
      end

      if (g == 0) begin : g_lo
         assign ptr_d = p;
      end else begin : g_hi
         assign ptr_e = p;
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_d <= ptr_e + PTR_W'(1));
   p_home_bounds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_d >= PTR_W'(LO_CELL)) && (ptr_e <= PTR_W'(HI_CELL)));
endmodule

// File: rtl/tsp_reorder_seq.sv
module tsp_reorder_seq #(
   parameter int DATA_W  = 16,
   parameter int DEPTH_W = 4,
   parameter int OFF_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               start_roll,
   input  logic [DEPTH_W-1:0] start_depth,
   input  logic [DATA_W-1:0]  rdata,
   output logic               active,
   output logic               last,
   output logic [OFF_W-1:0]   rd_off,
   output logic               wr_en,
   output logic [OFF_W-1:0]   wr_off,
   output logic [DATA_W-1:0]  wr_data
);
   localparam int SW = DEPTH_W + 2;

   logic [SW-1:0]      step, rd_s, wr_s, k;
   logic [DEPTH_W-1:0] depth_q;
   logic               roll_q;
   logic [DATA_W-1:0]  saved;

   assign k    = SW'(depth_q);
   assign last = active && (step == k + SW'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         step    <= '0;
         depth_q <= '0;
         roll_q  <= 1'b0;
         saved   <= '0;
      end else if (start) begin
         active  <= 1'b1;
         step    <= SW'(1);
         depth_q <= start_depth;
         roll_q  <= start_roll;
      end else if (active) begin
         if (last) active <= 1'b0;
         else      step   <= step + SW'(1);
         if (step == SW'(1)) saved <= rdata;
      end
   end

   // Offsets count cells from the next-empty slot toward the stack base:
   // offset j+1 addresses element j, offset 0 is the slot above the top.
   always_comb begin
      if (!roll_q) begin
         rd_s  = step + SW'(1);
         wr_en = active;
         if (step <= k + SW'(1)) begin
            wr_s    = step - SW'(1);
            wr_data = rdata;
         end else begin
            wr_s    = k + SW'(1);
            wr_data = saved;
         end
      end else begin
         rd_s  = k + SW'(1) - step;
         wr_en = active && (step >= SW'(2));
         if (step <= k + SW'(1)) begin
            wr_s    = k + SW'(3) - step;
            wr_data = rdata;
         end else begin
            wr_s    = SW'(1);
            wr_data = saved;
         end
      end
   end

   assign rd_off = OFF_W'(rd_s);
   assign wr_off = OFF_W'(wr_s);

   p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (step >= SW'(1)) && (step <= k + SW'(2)));
   p_no_rw_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step <= k) |-> !(wr_en && wr_off == rd_off));
   p_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !active);
endmodule

// File: rtl/twin_stack_pool.sv
module twin_stack_pool
   import twin_stack_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 9,
   parameter int LO_CELL = 6,
   parameter int HI_CELL = 511,
   parameter int DEPTH_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic               cmd_sel,
   input  logic [DEPTH_W-1:0] cmd_depth,
   input  logic [DATA_W-1:0]  cmd_wdata,
   output logic               busy,
   output logic               done,
   output logic [DATA_W-1:0]  rd_data,
   output logic [1:0]         err,
   output logic [ADDR_W:0]    data_ptr,
   output logic [ADDR_W:0]    exit_ptr
);
   localparam int PTR_W = ADDR_W + 1;

   if (HI_CELL >= (1 << ADDR_W)) begin : g_chk_hi
      $error("HI_CELL must fit in ADDR_W bits");
   end
   if (LO_CELL < 1 || LO_CELL >= HI_CELL) begin : g_chk_lo
      $error("LO_CELL must be at least 1 and below HI_CELL");
   end
   if (DEPTH_W + 2 > PTR_W) begin : g_chk_depth
      $error("DEPTH_W too large for the address width");
   end

   stk_op_e          op;
   stk_err_e         err_c, err_q;
   logic             accept, full, grow_c, shrink_c, we_c, start_c;
   logic             sel_q, end_grow_q, done_q, side;
   logic [PTR_W-1:0] ptr_d, ptr_e, cnt, depth_x, woff_c, roff_c;
   logic             seq_last, seq_we;
   logic [PTR_W-1:0] seq_roff, seq_woff;
   logic [DATA_W-1:0] seq_wd, q;

   function automatic logic [ADDR_W-1:0] slot(input logic s, input logic [PTR_W-1:0] pd,
                                             input logic [PTR_W-1:0] pe, input logic [PTR_W-1:0] off);
      logic [PTR_W-1:0] a;
      a = s ? (pe + off) : (pd - off);
      return a[ADDR_W-1:0];
   endfunction

   assign op      = stk_op_e'(cmd_op);
   assign accept  = cmd_valid && !busy;
   assign full    = (ptr_d == ptr_e + PTR_W'(1));
   assign cnt     = cmd_sel ? (PTR_W'(HI_CELL) - ptr_e) : (ptr_d - PTR_W'(LO_CELL));
   assign depth_x = PTR_W'(cmd_depth);

   always_comb begin
      err_c    = ERR_NONE;
      grow_c   = 1'b0;
      shrink_c = 1'b0;
      we_c     = 1'b0;
      start_c  = 1'b0;
      woff_c   = '0;
      roff_c   = PTR_W'(1);
      unique case (op)
         OP_PUSH:   if (full) err_c = ERR_OVF; else begin we_c = 1'b1; grow_c = 1'b1; end
         OP_POP:    if (cnt == '0) err_c = ERR_UNF; else shrink_c = 1'b1;
         OP_TOP:    if (cnt == '0) err_c = ERR_UNF;
         OP_SECOND: begin
            roff_c = PTR_W'(2);
            if (cnt < PTR_W'(2)) err_c = ERR_UNF;
         end
         OP_SETTOP: if (cnt == '0) err_c = ERR_UNF;
                    else begin we_c = 1'b1; woff_c = PTR_W'(1); end
         OP_TUCK:   if (depth_x >= cnt) err_c = ERR_REJ;
                    else if (full) err_c = ERR_OVF;
                    else start_c = 1'b1;
         OP_ROLL: begin
            roff_c = depth_x + PTR_W'(1);
            if (depth_x >= cnt) err_c = ERR_REJ; else start_c = 1'b1;
         end
         default:   err_c = ERR_REJ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q      <= 1'b0;
         end_grow_q <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= ERR_NONE;
      end else begin
         done_q <= (accept && !start_c) || seq_last;
         err_q  <= accept ? err_c : ERR_NONE;
         if (accept) begin
            sel_q      <= cmd_sel;
            end_grow_q <= (op == OP_TUCK);
         end
      end
   end

   assign side = busy ? sel_q : cmd_sel;

   tsp_ptr_pair #(.PTR_W(PTR_W), .LO_CELL(LO_CELL), .HI_CELL(HI_CELL)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (side),
      .grow   ((accept && grow_c) || (seq_last && end_grow_q)),
      .shrink (accept && shrink_c),
      .ptr_d  (ptr_d),
      .ptr_e  (ptr_e)
   );

   tsp_reorder_seq #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W), .OFF_W(PTR_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept && start_c),
      .start_roll  (op == OP_ROLL),
      .start_depth (cmd_depth),
      .rdata       (q),
      .active      (busy),
      .last        (seq_last),
      .rd_off      (seq_roff),
      .wr_en       (seq_we),
      .wr_off      (seq_woff),
      .wr_data     (seq_wd)
   );

   tsp_cell_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cells (
      .clk   (clk),
      .we    (busy ? seq_we : (accept && we_c)),
      .waddr (slot(side, ptr_d, ptr_e, busy ? seq_woff : woff_c)),
      .wdata (busy ? seq_wd : cmd_wdata),
      .raddr (slot(side, ptr_d, ptr_e, busy ? seq_roff : roff_c)),
      .rdata (q)
   );

   assign done     = done_q;
   assign err      = err_q;
   assign rd_data  = q;
   assign data_ptr = ptr_d;
   assign exit_ptr = ptr_e;

   p_done_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !start_c) |=> done && !busy);
   p_err_keeps_ptrs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && err_c != ERR_NONE) |=> (data_ptr == $past(data_ptr)) && (exit_ptr == $past(exit_ptr)));
   p_busy_ptrs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(seq_last && end_grow_q)) |=> $stable(data_ptr) && $stable(exit_ptr));
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/twin_stack_pool_tb_top.sv
module twin_stack_pool_tb_top;
   localparam int LO = 6;
   localparam int HI = 511;
   localparam int POOL = HI - LO + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic        cmd_sel = 1'b0;
   logic [3:0]  cmd_depth = '0;
   logic [15:0] cmd_wdata = '0;
   logic        busy, done;
   logic [15:0] rd_data;
   logic [1:0]  err;
   logic [9:0]  data_ptr, exit_ptr;

   int checks = 0;
   int failures = 0;
   logic [15:0] mdq[$];
   logic [15:0] meq[$];

   always #5 clk = ~clk;

   twin_stack_pool dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sel(cmd_sel), .cmd_depth(cmd_depth), .cmd_wdata(cmd_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .err(err),
      .data_ptr(data_ptr), .exit_ptr(exit_ptr)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // One command through the port, reference model updated first.
   task automatic run(input logic [2:0] op, input logic s, input int k,
                      input logic [15:0] wd, input string tag, input bit poke = 1'b0);
      logic [15:0] q[$];
      logic [15:0] v, exp_rd;
      logic [1:0]  exp_err;
      bit          has_rd;
      int          n, total, nb;
      if (s) q = meq; else q = mdq;
      n = q.size();
      total = mdq.size() + meq.size();
      exp_err = 2'd0; has_rd = 1'b0; nb = 0; exp_rd = '0;
      case (op)
         3'd0: if (total == POOL) exp_err = 2'd1; else q.push_front(wd);
         3'd1: if (n == 0) exp_err = 2'd2; else begin exp_rd = q.pop_front(); has_rd = 1'b1; end
         3'd2: if (n == 0) exp_err = 2'd2; else begin exp_rd = q[0]; has_rd = 1'b1; end
         3'd3: if (n < 2) exp_err = 2'd2; else begin exp_rd = q[1]; has_rd = 1'b1; end
         3'd4: if (n == 0) exp_err = 2'd2; else q[0] = wd;
         3'd5: if (k >= n) exp_err = 2'd3;
               else if (total == POOL) exp_err = 2'd1;
               else begin v = q[0]; q.insert(k + 1, v); nb = k + 2; end
         3'd6: if (k >= n) exp_err = 2'd3;
               else begin v = q[k]; q.delete(k); q.push_front(v); nb = k + 2; end
         default: exp_err = 2'd3;
      endcase
      if (s) meq = q; else mdq = q;

      cmd_valid = 1'b1; cmd_op = op; cmd_sel = s; cmd_depth = 4'(k); cmd_wdata = wd;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int c = 1; c <= nb; c++) begin
         chk(busy === 1'b1 && done === 1'b0, tag, "busy window", {30'd0, busy, done}, 32'd2);
         if (poke && c < nb) begin
            cmd_valid = 1'b1; cmd_op = 3'd0; cmd_sel = s; cmd_wdata = 16'hdead;
         end else cmd_valid = 1'b0;
         @(negedge clk);
      end
      chk(done === 1'b1 && busy === 1'b0, tag, "done pulse", {30'd0, busy, done}, 32'd1);
      chk(err === exp_err, tag, "err code", 32'(err), 32'(exp_err));
      if (has_rd) chk(rd_data === exp_rd, tag, "rd_data", 32'(rd_data), 32'(exp_rd));
      chk(data_ptr === 10'(LO + mdq.size()), tag, "data_ptr", 32'(data_ptr), 32'(LO + mdq.size()));
      chk(exit_ptr === 10'(HI - meq.size()), tag, "exit_ptr", 32'(exit_ptr), 32'(HI - meq.size()));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(data_ptr === 10'(LO), "R1", "data_ptr", 32'(data_ptr), LO);
      chk(exit_ptr === 10'(HI), "R1", "exit_ptr", 32'(exit_ptr), HI);
      chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done", {30'd0, busy, done}, 0);

      // R5 underflow on empty stacks, R10 rejected depths on empty
      run(3'd1, 1'b0, 0, 16'h0, "R5");
      run(3'd1, 1'b1, 0, 16'h0, "R5");
      run(3'd2, 1'b0, 0, 16'h0, "R5");
      run(3'd4, 1'b1, 0, 16'h1, "R5");
      run(3'd5, 1'b0, 0, 16'h0, "R10");
      run(3'd6, 1'b1, 0, 16'h0, "R10");

      // R2 / R12 pushes on both stacks
      run(3'd0, 1'b0, 0, 16'h0011, "R2");
      run(3'd3, 1'b0, 0, 16'h0, "R5");
      foreach (mdq[i]) ;
      run(3'd0, 1'b0, 0, 16'h0022, "R2");
      run(3'd0, 1'b1, 0, 16'h0a01, "R12");
      run(3'd0, 1'b0, 0, 16'h0033, "R2");
      run(3'd0, 1'b1, 0, 16'h0a02, "R12");
      run(3'd0, 1'b0, 0, 16'h0044, "R2");
      run(3'd0, 1'b1, 0, 16'h0a03, "R12");
      run(3'd0, 1'b0, 0, 16'h0055, "R2");
      run(3'd0, 1'b1, 0, 16'h0a04, "R12");

      // R6 reads without change, R7 overwrite
      run(3'd2, 1'b0, 0, 16'h0, "R6");
      run(3'd3, 1'b0, 0, 16'h0, "R6");
      run(3'd2, 1'b1, 0, 16'h0, "R6");
      run(3'd3, 1'b1, 0, 16'h0, "R6");
      run(3'd4, 1'b0, 0, 16'h0077, "R7");
      run(3'd2, 1'b0, 0, 16'h0, "R7");
      run(3'd3, 1'b0, 0, 16'h0, "R7");

      // R8 tuck, R9 roll, R11 ignored commands during busy
      run(3'd5, 1'b0, 0, 16'h0, "R8");
      run(3'd5, 1'b0, 1, 16'h0, "R8");
      run(3'd5, 1'b0, 3, 16'h0, "R11", 1'b1);
      run(3'd6, 1'b0, 1, 16'h0, "R9");
      run(3'd6, 1'b0, 2, 16'h0, "R9");
      run(3'd6, 1'b0, 4, 16'h0, "R9", 1'b1);
      run(3'd6, 1'b0, 0, 16'h0, "R9");
      run(3'd6, 1'b1, 3, 16'h0, "R9");
      run(3'd5, 1'b1, 2, 16'h0, "R8");
      run(3'd3, 1'b1, 0, 16'h0, "R8");

      // R10 depth equal to count, reserved op
      run(3'd5, 1'b1, meq.size(), 16'h0, "R10");
      run(3'd6, 1'b0, mdq.size(), 16'h0, "R10");
      run(3'd7, 1'b0, 0, 16'h0, "R10");

      // R4 drain both stacks in LIFO order
      while (mdq.size() > 0) run(3'd1, 1'b0, 0, 16'h0, "R4");
      while (meq.size() > 0) run(3'd1, 1'b1, 0, 16'h0, "R4");

      // R3 uneven fill to collision
      for (int i = 0; i < 300; i++) run(3'd0, 1'b0, 0, 16'(16'h1000 + i), "R3");
      while (mdq.size() + meq.size() < POOL)
         run(3'd0, 1'b1, 0, 16'(16'h8000 + meq.size()), "R3");
      run(3'd0, 1'b1, 0, 16'hbeef, "R3");
      run(3'd0, 1'b0, 0, 16'hbeef, "R3");
      run(3'd5, 1'b0, 0, 16'h0, "R10");
      run(3'd6, 1'b1, 1, 16'h0, "R9");
      run(3'd1, 1'b0, 0, 16'h0, "R3");
      run(3'd0, 1'b1, 0, 16'h4242, "R3");
      while (meq.size() > 0) run(3'd1, 1'b1, 0, 16'h0, "R4");
      while (mdq.size() > 0) run(3'd1, 1'b0, 0, 16'h0, "R4");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule